// File: doc/BRIEF.md
# Token-Passing LAN Control Frame Codec

This block sits between the protocol sequencer of a token-passing LAN node and its bit-level serializer and deserializer. It works on whole bytes. On the transmit side the sequencer asks for one of four control frames (token, free-buffer enquiry, positive acknowledge, negative acknowledge) and gives a destination node ID. The block then hands out the frame byte by byte over a valid/ready handshake. It flags the opening byte so that the serializer knows to put the alert burst in front of it.

On the receive side the deserializer delivers bytes that are already framed, with start-of-frame and end-of-frame markers. One cycle after the last byte of a frame, the block reports the frame's kind and its destination ID. It also reports whether the two copies of the ID disagreed and whether the frame is meant for this node.

A third, purely combinational path takes a data payload length and returns the header format it needs: short, long, or not encodable. It also returns the 8-bit offset count that goes into the header.

Top module: `ring_frame_codec`

## Requirements
- R1: With `tx_kind`=1, a request sends three bytes: 85h, then the destination ID, then the destination ID again. `tx_alert` is high only on the first byte and `tx_last` is high only on the third.
- R2: With `tx_kind`=0, a request sends a token of three bytes: 04h, then the destination ID twice. `tx_alert` and `tx_last` follow the rule of R1.
- R3: With `tx_kind`=2, a request sends the single byte 86h. With `tx_kind`=3, it sends the single byte 15h. On that one byte both `tx_alert` and `tx_last` are high.
- R4: `tx_req` is sampled only when `tx_busy` is low, and `tx_valid` rises in the following cycle. A byte stays unchanged while `tx_ready` is low. The frame ends one cycle after the last byte is accepted. A request made while busy is ignored and starts no frame.
- R5: The receiver reports `rx_kind` as follows: 1 = token (04h, exactly 3 bytes), 2 = enquiry (85h, exactly 3 bytes), 3 = acknowledge (86h, exactly 1 byte), 4 = negative acknowledge (15h, exactly 1 byte), 5 = data (01h, at least 4 bytes). The value 0 means no frame yet.
- R6: Any other first byte, or a known first byte with the wrong length, gives `rx_kind`=6, `rx_did`=0, `rx_id_bad`=0 and `rx_accept`=0.
- R7: In a token, enquiry or data frame, if the two destination ID copies differ, then `rx_id_bad`=1 and `rx_accept`=0. `rx_did` reports the first copy.
- R8: A data frame is laid out as 01h, source ID, destination ID, destination ID copy, and then the payload. A token or enquiry is accepted only when its ID equals `my_id`. A data frame is accepted when its ID equals `my_id` or is 00h (broadcast). Acknowledge and negative acknowledge are always accepted, with `rx_did`=0.
- R9: `rx_done` pulses for one cycle, in the cycle after the byte marked `rx_eof` is taken. The report outputs hold their values until the next frame ends. Cycles with `rx_valid` low are gaps and are ignored.
- R10: A payload length from 1 to 253 gives `pay_fmt`=1 (short) and `pay_count`=256−length.
- R11: A payload length from 257 to MAX_PAYLOAD (508 by default) gives `pay_fmt`=2 (long) and `pay_count`=512−length.
- R12: Lengths 254, 255 and 256, length 0, and any length above MAX_PAYLOAD give `pay_fmt`=0 and `pay_count`=0.
- R13: While `rst` is high, `tx_valid`, `tx_busy` and `rx_done` are 0, and `rx_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 8 | This node's ID, used for receive address matching |
| tx_req | input | 1 | Request a control frame (sampled when idle) |
| tx_kind | input | 2 | 0 token, 1 enquiry, 2 acknowledge, 3 negative acknowledge |
| tx_did | input | 8 | Destination ID for the requested frame |
| tx_busy | output | 1 | A frame is being sent |
| tx_valid | output | 1 | `tx_byte` holds a byte to send |
| tx_ready | input | 1 | Serializer takes the byte this cycle |
| tx_byte | output | 8 | Outgoing byte |
| tx_alert | output | 1 | First byte of the frame; an alert burst precedes it |
| tx_last | output | 1 | Final byte of the frame |
| rx_valid | input | 1 | `rx_byte` carries a received byte |
| rx_sof | input | 1 | This byte is the first after the alert burst |
| rx_eof | input | 1 | This byte ends the frame |
| rx_byte | input | 8 | Received byte |
| rx_done | output | 1 | One-cycle pulse: frame report is fresh |
| rx_kind | output | 3 | Frame kind code (see R5, R6) |
| rx_did | output | 8 | Destination ID (first copy) |
| rx_id_bad | output | 1 | ID copies disagreed |
| rx_accept | output | 1 | Frame is well formed and addressed to this node |
| pay_len | input | LEN_W | Data payload length in bytes |
| pay_fmt | output | 2 | 0 not encodable, 1 short, 2 long |
| pay_count | output | 8 | Header offset count for the payload |

## Verification
Some rules are checked by the assertions on every cycle. These are: a transmit byte is held stable under back-pressure, the valid signal drops right after the last byte is accepted, the single-byte acknowledges carry the last-byte flag, a frame report never comes without a preceding end-of-frame byte, a disagreeing ID pair is never accepted, an accepted data frame is always for this node or broadcast, and the forbidden lengths are never given a format. The exact byte order of each transmitted frame, the ignoring of requests made mid-frame, and the full classification cannot be seen by those rules. The classification covers wrong-length frames, unknown type codes and addressing against a given node ID, and only the bench's directed and random frames, compared against a reference model, show it.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    localparam logic [7:0] CODE_SOH = 8'h01;
    localparam logic [7:0] CODE_EOT = 8'h04;
    localparam logic [7:0] CODE_ENQ = 8'h85;
    localparam logic [7:0] CODE_ACK = 8'h86;
    localparam logic [7:0] CODE_NAK = 8'h15;

    typedef enum logic [1:0] {
        TXK_TOKEN = 2'd0,
        TXK_ENQ   = 2'd1,
        TXK_ACK   = 2'd2,
        TXK_NAK   = 2'd3
    } tx_kind_e;

    typedef enum logic [2:0] {
        RXK_NONE    = 3'd0,
        RXK_TOKEN   = 3'd1,
        RXK_ENQ     = 3'd2,
        RXK_ACK     = 3'd3,
        RXK_NAK     = 3'd4,
        RXK_DATA    = 3'd5,
        RXK_UNKNOWN = 3'd6
    } rx_kind_e;

    typedef enum logic [1:0] {
        PF_ILLEGAL = 2'd0,
        PF_SHORT   = 2'd1,
        PF_LONG    = 2'd2
    } pay_fmt_e;

    typedef struct packed {
        rx_kind_e   kind;
        logic [7:0] did;
        logic       id_bad;
        logic       accept;
    } rx_report_t;

    // Number of bytes after the alert burst for a control frame
    function automatic logic [1:0] tx_frame_len(tx_kind_e k);
        return (k == TXK_TOKEN || k == TXK_ENQ) ? 2'd3 : 2'd1;
    endfunction

    // Type code that opens a control frame
    function automatic logic [7:0] tx_type_code(tx_kind_e k);
        case (k)
            TXK_TOKEN: return CODE_EOT;
            TXK_ENQ:   return CODE_ENQ;
            TXK_ACK:   return CODE_ACK;
            default:   return CODE_NAK;
        endcase
    endfunction

endpackage

// File: rtl/rfc_tx_fmt.sv
module rfc_tx_fmt
    import rfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  tx_kind_e   kind,
    input  logic [7:0] did,
    input  logic       ready,
    output logic       busy,
    output logic       valid,
    output logic [7:0] byte_o,
    output logic       alert,
    output logic       last
);

    logic       busy_q;
    logic [1:0] idx_q;
    tx_kind_e   kind_q;
    logic [7:0] did_q;
    logic       last_w;

    assign last_w = (idx_q == (tx_frame_len(kind_q) - 2'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= 2'd0;
            kind_q <= TXK_TOKEN;
            did_q  <= 8'd0;
        end else if (!busy_q) begin
            if (req) begin
                busy_q <= 1'b1;
                idx_q  <= 2'd0;
                kind_q <= kind;
                did_q  <= did;
            end
        end else if (ready) begin
            if (last_w) begin
                busy_q <= 1'b0;
            end
            idx_q <= idx_q + 2'd1;
        end
    end

    assign busy   = busy_q;
    assign valid  = busy_q;
    assign byte_o = (idx_q == 2'd0) ? tx_type_code(kind_q) : did_q;
    assign alert  = busy_q && (idx_q == 2'd0);
    assign last   = busy_q && last_w;

endmodule

// File: rtl/rfc_rx_class.sv
module rfc_rx_class
    import rfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] my_id,
    input  logic       valid,
    input  logic       sof,
    input  logic       eof,
    input  logic [7:0] byte_i,
    output logic       done,
    output rx_report_t report
);

    logic [2:0] cnt_q;
    logic [7:0] type_q, id1_q, id2_q;
    logic       done_q;
    rx_report_t rep_q;

    logic [2:0] cur_idx, pos1;
    logic [7:0] cur_type, id1_e, id2_e;
    logic [3:0] nbytes;
    rx_kind_e   kind_n;
    rx_report_t rep_n;

    always_comb begin
        cur_idx  = sof ? 3'd0 : cnt_q;
        cur_type = (cur_idx == 3'd0) ? byte_i : type_q;
        pos1     = (cur_type == CODE_SOH) ? 3'd2 : 3'd1;
        id1_e    = (cur_idx == pos1) ? byte_i : id1_q;
        id2_e    = (cur_idx == pos1 + 3'd1) ? byte_i : id2_q;
        nbytes   = {1'b0, cur_idx} + 4'd1;

        if (cur_type == CODE_EOT && nbytes == 4'd3)       kind_n = RXK_TOKEN;
        else if (cur_type == CODE_ENQ && nbytes == 4'd3)  kind_n = RXK_ENQ;
        else if (cur_type == CODE_ACK && nbytes == 4'd1)  kind_n = RXK_ACK;
        else if (cur_type == CODE_NAK && nbytes == 4'd1)  kind_n = RXK_NAK;
        else if (cur_type == CODE_SOH && nbytes >= 4'd4)  kind_n = RXK_DATA;
        else                                              kind_n = RXK_UNKNOWN;

        rep_n.kind = kind_n;
        case (kind_n)
            RXK_TOKEN, RXK_ENQ: begin
                rep_n.did    = id1_e;
                rep_n.id_bad = (id1_e != id2_e);
                rep_n.accept = (id1_e == id2_e) && (id1_e == my_id);
            end
            RXK_DATA: begin
                rep_n.did    = id1_e;
                rep_n.id_bad = (id1_e != id2_e);
                rep_n.accept = (id1_e == id2_e) && ((id1_e == my_id) || (id1_e == 8'h00));
            end
            RXK_ACK, RXK_NAK: begin
                rep_n.did    = 8'h00;
                rep_n.id_bad = 1'b0;
                rep_n.accept = 1'b1;
            end
            default: begin
                rep_n.did    = 8'h00;
                rep_n.id_bad = 1'b0;
                rep_n.accept = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= 3'd0;
            type_q <= 8'd0;
            id1_q  <= 8'd0;
            id2_q  <= 8'd0;
            done_q <= 1'b0;
            rep_q  <= '{kind: RXK_NONE, did: 8'd0, id_bad: 1'b0, accept: 1'b0};
        end else begin
            done_q <= 1'b0;
            if (valid) begin
                cnt_q  <= (cur_idx == 3'd7) ? 3'd7 : cur_idx + 3'd1;
                type_q <= cur_type;
                id1_q  <= id1_e;
                id2_q  <= id2_e;
                if (eof) begin
                    done_q <= 1'b1;
                    rep_q  <= rep_n;
                end
            end
        end
    end

    assign done   = done_q;
    assign report = rep_q;

endmodule

// File: rtl/rfc_len_class.sv
module rfc_len_class
    import rfc_pkg::*;
#(
    parameter int MAX_PAYLOAD = 508,
    parameter int LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic [LEN_W-1:0] len,
    output pay_fmt_e         fmt,
    output logic [7:0]       count
);

    localparam int CW = (LEN_W > 10) ? LEN_W : 10;

    logic [CW-1:0] l;
    logic          is_short, is_long;

    always_comb begin
        l        = CW'(len);
        is_short = (l >= CW'(1)) && (l <= CW'(253));
        is_long  = (l >= CW'(257)) && (l <= CW'(MAX_PAYLOAD));
        if (is_short)     fmt = PF_SHORT;
        else if (is_long) fmt = PF_LONG;
        else              fmt = PF_ILLEGAL;
        // 256-l and 512-l share their low byte: the two's complement of l
        count = (is_short || is_long) ? (8'd0 - l[7:0]) : 8'd0;
    end

endmodule

// File: rtl/ring_frame_codec.sv
module ring_frame_codec
    import rfc_pkg::*;
#(
    parameter int MAX_PAYLOAD = 508,
    parameter int LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       my_id,
    input  logic             tx_req,
    input  logic [1:0]       tx_kind,
    input  logic [7:0]       tx_did,
    output logic             tx_busy,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_byte,
    output logic             tx_alert,
    output logic             tx_last,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_byte,
    output logic             rx_done,
    output logic [2:0]       rx_kind,
    output logic [7:0]       rx_did,
    output logic             rx_id_bad,
    output logic             rx_accept,
    input  logic [LEN_W-1:0] pay_len,
    output logic [1:0]       pay_fmt,
    output logic [7:0]       pay_count
);

    rx_report_t rep;
    pay_fmt_e   fmt;

    rfc_tx_fmt u_tx (
        .clk    (clk),
        .rst    (rst),
        .req    (tx_req),
        .kind   (tx_kind_e'(tx_kind)),
        .did    (tx_did),
        .ready  (tx_ready),
        .busy   (tx_busy),
        .valid  (tx_valid),
        .byte_o (tx_byte),
        .alert  (tx_alert),
        .last   (tx_last)
    );

    rfc_rx_class u_rx (
        .clk    (clk),
        .rst    (rst),
        .my_id  (my_id),
        .valid  (rx_valid),
        .sof    (rx_sof),
        .eof    (rx_eof),
        .byte_i (rx_byte),
        .done   (rx_done),
        .report (rep)
    );

    rfc_len_class #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .LEN_W       (LEN_W)
    ) u_len (
        .len   (pay_len),
        .fmt   (fmt),
        .count (pay_count)
    );

    assign rx_kind   = rep.kind;
    assign rx_did    = rep.did;
    assign rx_id_bad = rep.id_bad;
    assign rx_accept = rep.accept;
    assign pay_fmt   = fmt;

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker
    import rfc_pkg::*;
#(
    parameter int MAX_PAYLOAD = 508,
    parameter int LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       my_id,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_byte,
    input logic             tx_alert,
    input logic             tx_last,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             rx_done,
    input logic [2:0]       rx_kind,
    input logic [7:0]       rx_did,
    input logic             rx_id_bad,
    input logic             rx_accept,
    input logic [LEN_W-1:0] pay_len,
    input logic [1:0]       pay_fmt
);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last)); // R4

    AST_TX_END: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && tx_last |=> !tx_valid); // R4

    AST_ONE_BYTE_ACK: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_alert && (tx_byte == CODE_ACK || tx_byte == CODE_NAK) |-> tx_last); // R3

    AST_OPEN_TYPE: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_alert |-> (tx_byte == CODE_EOT || tx_byte == CODE_ENQ ||
                                  tx_byte == CODE_ACK || tx_byte == CODE_NAK)); // R2

    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $past(rx_valid && rx_eof)); // R9

    AST_BAD_ID_DROP: assert property (@(posedge clk) disable iff (rst)
        rx_done && rx_id_bad |-> !rx_accept); // R7

    AST_DATA_ADDR: assert property (@(posedge clk) disable iff (rst)
        rx_done && rx_accept && rx_kind == RXK_DATA |->
            (rx_did == $past(my_id) || rx_did == 8'h00)); // R8

    AST_FORBIDDEN_LEN: assert property (@(posedge clk) disable iff (rst)
        (pay_len >= LEN_W'(254) && pay_len <= LEN_W'(256)) |-> pay_fmt == PF_ILLEGAL); // R12

    AST_LONG_RANGE: assert property (@(posedge clk) disable iff (rst)
        pay_fmt == PF_LONG |-> pay_len >= LEN_W'(257)); // R11

endmodule

bind ring_frame_codec rfc_checker #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .LEN_W       (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .my_id     (my_id),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .tx_alert  (tx_alert),
    .tx_last   (tx_last),
    .rx_valid  (rx_valid),
    .rx_eof    (rx_eof),
    .rx_done   (rx_done),
    .rx_kind   (rx_kind),
    .rx_did    (rx_did),
    .rx_id_bad (rx_id_bad),
    .rx_accept (rx_accept),
    .pay_len   (pay_len),
    .pay_fmt   (pay_fmt)
);

// File: tb/ring_frame_codec_tb.sv
module ring_frame_codec_tb;

    localparam int MAXP = 508;
    localparam int LW   = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    my_id = 8'h2A;
    logic          tx_req = 1'b0;
    logic [1:0]    tx_kind = 2'd0;
    logic [7:0]    tx_did = 8'd0;
    logic          tx_busy, tx_valid, tx_alert, tx_last;
    logic          tx_ready = 1'b0;
    logic [7:0]    tx_byte;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]    rx_byte = 8'd0;
    logic          rx_done, rx_id_bad, rx_accept;
    logic [2:0]    rx_kind;
    logic [7:0]    rx_did;
    logic [LW-1:0] pay_len = '0;
    logic [1:0]    pay_fmt;
    logic [7:0]    pay_count;

    int checks = 0;
    int errors = 0;
    logic [7:0] fb [0:15];
    int seed_sink;

    ring_frame_codec #(.MAX_PAYLOAD(MAXP), .LEN_W(LW)) u_dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_n(input int k);
        return (k < 2) ? 3 : 1;
    endfunction

    function automatic logic [7:0] exp_b(input int k, input logic [7:0] did, input int i);
        if (i > 0) return did;
        case (k)
            0: return 8'h04;
            1: return 8'h85;
            2: return 8'h86;
            default: return 8'h15;
        endcase
    endfunction

    task automatic model_rx(input int n, output int kind, output int did, output int bad, output int acc);
        logic [7:0] t;
        t = fb[0];
        if (t == 8'h04 && n == 3)      kind = 1;
        else if (t == 8'h85 && n == 3) kind = 2;
        else if (t == 8'h86 && n == 1) kind = 3;
        else if (t == 8'h15 && n == 1) kind = 4;
        else if (t == 8'h01 && n >= 4) kind = 5;
        else                           kind = 6;
        did = 0; bad = 0; acc = 0;
        if (kind == 1 || kind == 2) begin
            did = int'(fb[1]); bad = int'(fb[1] != fb[2]);
            acc = int'(bad == 0 && fb[1] == my_id);
        end else if (kind == 5) begin
            did = int'(fb[2]); bad = int'(fb[2] != fb[3]);
            acc = int'(bad == 0 && (fb[2] == my_id || fb[2] == 8'h00));
        end else if (kind == 3 || kind == 4) begin
            acc = 1;
        end
    endtask

    task automatic tx_frame(input int k, input logic [7:0] did, input bit stall, input bit poke);
        int got, guard, held;
        bit hh, ok, poked;
        string tag;
        tag = (k == 0) ? "R2" : (k == 1) ? "R1" : "R3";
        @(negedge clk);
        tx_req = 1'b1; tx_kind = 2'(k); tx_did = did; tx_ready = 1'b0;
        @(negedge clk);
        tx_req = 1'b0;
        got = 0; guard = 0; hh = 0; ok = 1; poked = 0; held = 0;
        while (got < exp_n(k) && guard < 60) begin
            logic r;
            r = stall ? 1'($urandom % 2) : 1'b1;
            tx_ready = r;
            if (poke && got == 1 && !poked) begin
                tx_req = 1'b1; tx_kind = 2'd3; tx_did = 8'h99; poked = 1;
            end else begin
                tx_req = 1'b0;
            end
            #1;
            if (tx_valid) begin
                if (!r) begin
                    if (hh) chk(int'(tx_byte) == held, "R4", "byte under stall", int'(tx_byte), held);
                    held = int'(tx_byte); hh = 1;
                end else begin
                    if (hh) chk(int'(tx_byte) == held, "R4", "held byte accepted", int'(tx_byte), held);
                    hh = 0;
                    if (tx_byte != exp_b(k, did, got) || tx_alert != (got == 0) ||
                        tx_last != (got == exp_n(k) - 1)) begin
                        ok = 0;
                        $display("  byte %0d: %0h alert %0b last %0b", got, tx_byte, tx_alert, tx_last);
                    end
                    got++;
                end
            end
            guard++;
            @(negedge clk);
        end
        tx_ready = 1'b0; tx_req = 1'b0;
        #1;
        chk(ok && got == exp_n(k), tag, "frame bytes/flags", got, exp_n(k));
        chk(!tx_valid && !tx_busy, "R4", "idle after last byte", int'({tx_valid, tx_busy}), 0);
        if (poke) begin
            bit quiet;
            quiet = 1;
            repeat (3) begin
                @(negedge clk); #1;
                if (tx_valid || tx_busy) quiet = 0;
            end
            chk(quiet, "R4", "request while busy ignored", int'(!quiet), 0);
        end
    endtask

    task automatic rx_frame(input int n, input bit gaps);
        int ek, ed, eb, ea, act, exp;
        string tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps && ($urandom % 3) == 0) begin
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_byte = 8'hEE;
                @(negedge clk);
            end
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_byte = fb[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        #1;
        model_rx(n, ek, ed, eb, ea);
        if (eb != 0)                        tag = "R7";
        else if (ek == 6)                   tag = "R6";
        else if (ek == 5 || (ek <= 2 && ea == 0)) tag = "R8";
        else                                tag = "R5";
        act = int'({rx_done, rx_kind, rx_did, rx_id_bad, rx_accept});
        exp = (1 << 13) | (ek << 10) | (ed << 2) | (eb << 1) | ea;
        chk(act == exp, tag, "rx report {done,kind,did,bad,acc}", act, exp);
        @(negedge clk); #1;
        act = int'({rx_done, rx_kind, rx_did, rx_id_bad, rx_accept});
        exp = (ek << 10) | (ed << 2) | (eb << 1) | ea;
        chk(act == exp, "R9", "done pulse one cycle, report held", act, exp);
    endtask

    task automatic len_chk(input int l);
        int ef, ec;
        string tag;
        if (l >= 1 && l <= 253)        begin ef = 1; ec = 256 - l; tag = "R10"; end
        else if (l >= 257 && l <= MAXP) begin ef = 2; ec = 512 - l; tag = "R11"; end
        else                           begin ef = 0; ec = 0; tag = "R12"; end
        @(negedge clk);
        pay_len = LW'(l);
        #1;
        chk(int'(pay_fmt) == ef && int'(pay_count) == ec, tag, "length format/count",
            int'({pay_fmt, pay_count}), (ef << 8) | ec);
    endtask

    task automatic set_ctrl(input logic [7:0] t, input logic [7:0] d);
        fb[0] = t; fb[1] = d; fb[2] = d;
    endtask

    task automatic set_data(input logic [7:0] d, input int n);
        fb[0] = 8'h01; fb[1] = 8'h11; fb[2] = d; fb[3] = d;
        for (int i = 4; i < n; i++) fb[i] = 8'($urandom);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        #1;
        chk(!tx_valid && !tx_busy && !rx_done && rx_kind == 3'd0, "R13", "reset state",
            int'({tx_valid, tx_busy, rx_done, rx_kind}), 0);
        rst = 1'b0;

        // directed transmit frames
        tx_frame(0, 8'h2A, 0, 0);
        tx_frame(1, 8'h07, 1, 1);
        tx_frame(2, 8'h00, 0, 0);
        tx_frame(3, 8'h00, 1, 0);
        tx_frame(0, 8'hFF, 1, 1);
        for (int i = 0; i < 20; i++)
            tx_frame(int'($urandom % 4), 8'($urandom), 1'($urandom % 2), 0);

        // directed receive frames
        set_ctrl(8'h04, 8'h2A); rx_frame(3, 0);          // token to this node
        set_ctrl(8'h85, 8'h33); rx_frame(3, 1);          // enquiry to another node
        fb[0] = 8'h86; rx_frame(1, 0);                   // acknowledge
        fb[0] = 8'h15; rx_frame(1, 1);                   // negative acknowledge
        set_data(8'h00, 6); rx_frame(6, 0);              // broadcast data
        set_data(8'h2A, 4); rx_frame(4, 1);              // data to this node
        set_data(8'h51, 9); rx_frame(9, 0);              // data to another node
        set_ctrl(8'h04, 8'h2A); fb[2] = 8'h2B; rx_frame(3, 0); // ID copies differ
        set_data(8'h2A, 5); fb[3] = 8'h00; rx_frame(5, 0);     // data copies differ
        fb[0] = 8'h86; fb[1] = 8'h86; rx_frame(2, 0);    // acknowledge too long
        fb[0] = 8'h77; rx_frame(1, 0);                   // unknown type
        set_data(8'h2A, 4); rx_frame(3, 0);              // data too short

        // random receive frames
        for (int i = 0; i < 60; i++) begin
            int c, n;
            logic [7:0] d;
            c = int'($urandom % 6);
            case ($urandom % 3)
                0: d = my_id;
                1: d = 8'h00;
                default: d = 8'($urandom);
            endcase
            case (c)
                0: begin set_ctrl(8'h04, d); n = 3; end
                1: begin set_ctrl(8'h85, d); n = 3; end
                2: begin fb[0] = 8'h86; n = 1; end
                3: begin fb[0] = 8'h15; n = 1; end
                4: begin n = 4 + int'($urandom % 8); set_data(d, n); end
                default: begin
                    n = 1 + int'($urandom % 4);
                    for (int j = 0; j < n; j++) fb[j] = 8'($urandom);
                end
            endcase
            if (($urandom % 5) == 0 && (c == 0 || c == 1)) fb[2] = fb[2] ^ (8'h01 << ($urandom % 8));
            if (($urandom % 5) == 0 && c == 4) fb[3] = fb[3] ^ (8'h01 << ($urandom % 8));
            if (($urandom % 10) == 0 && c < 4) begin fb[n] = 8'($urandom); n = n + 1; end
            rx_frame(n, 1'($urandom % 2));
        end

        // payload length rule
        len_chk(0);   len_chk(1);   len_chk(253); len_chk(254); len_chk(255);
        len_chk(256); len_chk(257); len_chk(508); len_chk(509); len_chk(511);
        for (int i = 0; i < 40; i++) len_chk(int'($urandom % 512));

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule